// File: doc/BRIEF.md
# Dual-Range Current Acquisition Combiner

This block turns the raw activity of one loss-monitor input channel into a single integrated value for each fixed acquisition period. The period is a programmable number of clock cycles; it is 2 µs at the intended clock. While the channel is in its low-current range, a dual-polarity current-to-frequency front end flips a status line each time its integrator crosses a threshold. The block counts those flips. It then adds the count, scaled by a charge-per-flip weight, to the change in the integrator voltage that the ADC reads between the opening and the closing of the period. While the channel is in its high-current range, the block takes the ADC reading at the close of the period directly and scales it by a programmable factor.

The block requests one ADC conversion at the first cycle of every period. That conversion closes the previous period and opens the current one, so the result for a period appears during the period that follows it. The block picks the range without outside help. A period whose flip count reaches a programmable maximum moves the channel to direct-ADC mode. In direct mode, an ADC reading below a programmable level moves the channel back. Range changes take effect only at a period boundary. Both ranges give results in the same unit, with no gain step. The result is 32 bits unsigned and saturates at both ends.

Top module: `dual_range_combiner`

## Requirements
- R1: While reset is asserted, sample_valid_o and range_direct_o are 0. The channel leaves reset in frequency-converter mode (range_direct_o = 0).
- R2: adc_convert_o is high for exactly one cycle out of every PERIOD_CYC cycles. The first such cycle is the first cycle after reset is released.
- R3: sample_valid_o is high for one cycle in the cycle after each adc_valid_i pulse, except the first adc_valid_i pulse after reset, which only supplies the opening reading. No result appears at any other time.
- R4: A rising edge on pulse_p_i or on pulse_n_i counts as one status flip. Rising edges on both inputs in the same cycle count as two. The count saturates at all ones.
- R5: A period run in frequency-converter mode yields count × cfg_weight_i + (closing reading − opening reading). The closing reading is the ADC value returned for the conversion at the end of that period. The opening reading is the value returned for the conversion at its start.
- R6: At the end of a frequency-converter period whose flip count is greater than or equal to cfg_max_count_i, range_direct_o becomes 1. The change appears in the same cycle as the next adc_convert_o pulse.
- R7: In direct mode, an adc_valid_i reading below cfg_low_thresh_i makes range_direct_o return to 0 at the next period boundary.
- R8: A period run in direct-ADC mode yields closing reading × cfg_scale_i. Status flips during that period have no effect on the result.
- R9: A result below 0 is output as 0. A result above 2^32 − 1 is output as 2^32 − 1.
- R10: range_direct_o changes only in a cycle where adc_convert_o is high. sample_mode_o gives the mode that was active for the whole reported period: 0 for frequency-converter mode, 1 for direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_p_i | input | 1 | Synchronized status line, rises on a low-to-high flip |
| pulse_n_i | input | 1 | Synchronized status line, rises on a high-to-low flip |
| adc_valid_i | input | 1 | One-cycle strobe: adc_data_i holds a finished conversion |
| adc_data_i | input | ADC_W | ADC reading |
| cfg_max_count_i | input | CNT_W | Flip count that moves the channel to direct mode |
| cfg_low_thresh_i | input | ADC_W | Reading below which direct mode is left |
| cfg_weight_i | input | WGT_W | Charge-per-flip weight |
| cfg_scale_i | input | SCL_W | Direct-mode scale factor |
| adc_convert_o | output | 1 | Conversion request, one cycle at each period start |
| range_direct_o | output | 1 | Range select: 1 means direct-ADC mode |
| sample_valid_o | output | 1 | Result strobe |
| sample_value_o | output | OUT_W | Integrated, saturated period result |
| sample_mode_o | output | 1 | Mode of the reported period |

## Verification
The flip inputs are driven in three patterns: alternating single flips, flips on one line only, and flips on both lines in the same cycle. These separate simple edge counting from counting two edges in one cycle, and the patterns land on both sides of the switch-over count. ADC readings are stepped up and down around a base level. Rising steps test the sign of the end-point difference. A large drop with zero weight drives the result below zero. Readings moved above and below the return threshold exercise the hysteresis in both directions. A very large weight and a very large scale push each mode past the top of the output range. Flips are kept running in direct mode to show that they do not affect the result.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic {
    RANGE_FC     = 1'b0,
    RANGE_DIRECT = 1'b1
  } range_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/drc_period_timer.sv
module drc_period_timer #(
  parameter int unsigned PERIOD_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic start_o,
  output logic end_o
);

  localparam int unsigned CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign start_o = (cnt_q == '0);
  assign end_o   = at_last;

endmodule

// File: rtl/drc_toggle_counter.sv
module drc_toggle_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_p_i,
  input  logic             pulse_n_i,
  input  logic             end_i,
  output logic [CNT_W-1:0] total_o
);

  logic             p_q, n_q;
  logic [1:0]       inc;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // two edge detectors; both may fire in one cycle
  always_comb begin
    inc = {1'b0, pulse_p_i & ~p_q} + {1'b0, pulse_n_i & ~n_q};
    sum = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, inc};
    total_o = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    cnt_d = end_i ? '0 : total_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q   <= 1'b0;
      n_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      p_q   <= pulse_p_i;
      n_q   <= pulse_n_i;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/drc_range_ctrl.sv
module drc_range_ctrl #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ADC_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 end_i,
  input  logic [CNT_W-1:0]     total_i,
  input  logic [CNT_W-1:0]     cfg_max_count_i,
  input  logic                 adc_valid_i,
  input  logic [ADC_W-1:0]     adc_data_i,
  input  logic [ADC_W-1:0]     cfg_low_thresh_i,
  output drc_pkg::range_e      mode_o
);

  import drc_pkg::*;

  range_e mode_q, mode_d;
  logic   back_q, back_d;
  logic   low_seen;

  assign low_seen = adc_valid_i && (mode_q == RANGE_DIRECT) && (adc_data_i < cfg_low_thresh_i);

  always_comb begin
    mode_d = mode_q;
    back_d = back_q;
    if (end_i) begin
      back_d = 1'b0;
      if (mode_q == RANGE_FC) begin
        if (total_i >= cfg_max_count_i) mode_d = RANGE_DIRECT;
      end else if (back_q) begin
        mode_d = RANGE_FC;
      end
    end else if (low_seen) begin
      back_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RANGE_FC;
      back_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      back_q <= back_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/drc_sample_combiner.sv
module drc_sample_combiner #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned ADC_W = 16,
  parameter int unsigned WGT_W = 32,
  parameter int unsigned SCL_W = 24,
  parameter int unsigned OUT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 end_i,
  input  logic [CNT_W-1:0]     total_i,
  input  drc_pkg::range_e      mode_i,
  input  logic                 adc_valid_i,
  input  logic [ADC_W-1:0]     adc_data_i,
  input  logic [WGT_W-1:0]     cfg_weight_i,
  input  logic [SCL_W-1:0]     cfg_scale_i,
  output logic                 valid_o,
  output logic [OUT_W-1:0]     value_o,
  output logic                 mode_o
);

  import drc_pkg::*;

  localparam int unsigned FPROD_W = CNT_W + WGT_W;
  localparam int unsigned DPROD_W = ADC_W + SCL_W;
  localparam int unsigned SUM_W   = max_of(max_of(FPROD_W, DPROD_W), max_of(OUT_W, ADC_W)) + 2;

  logic [CNT_W-1:0]        snap_cnt_q, snap_cnt_d;
  range_e                  snap_mode_q, snap_mode_d;
  logic [ADC_W-1:0]        prev_q, prev_d;
  logic                    have_prev_q, have_prev_d;
  logic                    valid_q, valid_d;
  logic [OUT_W-1:0]        value_q, value_d;
  logic                    mode_q, mode_d;

  logic [FPROD_W-1:0]      fc_prod;
  logic [DPROD_W-1:0]      dir_prod;
  logic signed [SUM_W-1:0] fc_sum, dir_sum, sel_sum;
  logic [OUT_W-1:0]        sat_val;

  always_comb begin
    fc_prod  = FPROD_W'(snap_cnt_q) * FPROD_W'(cfg_weight_i);
    dir_prod = DPROD_W'(adc_data_i) * DPROD_W'(cfg_scale_i);
    fc_sum   = $signed({{(SUM_W-FPROD_W){1'b0}}, fc_prod})
             + $signed({{(SUM_W-ADC_W){1'b0}}, adc_data_i})
             - $signed({{(SUM_W-ADC_W){1'b0}}, prev_q});
    dir_sum  = $signed({{(SUM_W-DPROD_W){1'b0}}, dir_prod});
    sel_sum  = (snap_mode_q == RANGE_DIRECT) ? dir_sum : fc_sum;
    if (sel_sum[SUM_W-1]) begin
      sat_val = '0;
    end else if (|sel_sum[SUM_W-2:OUT_W]) begin
      sat_val = {OUT_W{1'b1}};
    end else begin
      sat_val = sel_sum[OUT_W-1:0];
    end
  end

  // snapshot at period end, result on the closing reading
  always_comb begin
    snap_cnt_d  = snap_cnt_q;
    snap_mode_d = snap_mode_q;
    prev_d      = prev_q;
    have_prev_d = have_prev_q;
    valid_d     = 1'b0;
    value_d     = value_q;
    mode_d      = mode_q;
    if (end_i) begin
      snap_cnt_d  = total_i;
      snap_mode_d = mode_i;
    end
    if (adc_valid_i) begin
      prev_d      = adc_data_i;
      have_prev_d = 1'b1;
      if (have_prev_q) begin
        valid_d = 1'b1;
        value_d = sat_val;
        mode_d  = (snap_mode_q == RANGE_DIRECT);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_cnt_q  <= '0;
      snap_mode_q <= RANGE_FC;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      valid_q     <= 1'b0;
      value_q     <= '0;
      mode_q      <= 1'b0;
    end else begin
      snap_cnt_q  <= snap_cnt_d;
      snap_mode_q <= snap_mode_d;
      prev_q      <= prev_d;
      have_prev_q <= have_prev_d;
      valid_q     <= valid_d;
      value_q     <= value_d;
      mode_q      <= mode_d;
    end
  end

  assign valid_o = valid_q;
  assign value_o = value_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/dual_range_combiner.sv
module dual_range_combiner #(
  parameter int unsigned PERIOD_CYC = 200,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ADC_W      = 16,
  parameter int unsigned WGT_W      = 32,
  parameter int unsigned SCL_W      = 24,
  parameter int unsigned OUT_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_p_i,
  input  logic             pulse_n_i,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic [CNT_W-1:0] cfg_max_count_i,
  input  logic [ADC_W-1:0] cfg_low_thresh_i,
  input  logic [WGT_W-1:0] cfg_weight_i,
  input  logic [SCL_W-1:0] cfg_scale_i,
  output logic             adc_convert_o,
  output logic             range_direct_o,
  output logic             sample_valid_o,
  output logic [OUT_W-1:0] sample_value_o,
  output logic             sample_mode_o
);

  import drc_pkg::*;

  logic             per_start, per_end;
  logic [CNT_W-1:0] flip_total;
  range_e           cur_mode;

  drc_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_o(per_start),
    .end_o  (per_end)
  );

  drc_toggle_counter #(.CNT_W(CNT_W)) u_flips (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_p_i(pulse_p_i),
    .pulse_n_i(pulse_n_i),
    .end_i    (per_end),
    .total_o  (flip_total)
  );

  drc_range_ctrl #(.CNT_W(CNT_W), .ADC_W(ADC_W)) u_range (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .end_i           (per_end),
    .total_i         (flip_total),
    .cfg_max_count_i (cfg_max_count_i),
    .adc_valid_i     (adc_valid_i),
    .adc_data_i      (adc_data_i),
    .cfg_low_thresh_i(cfg_low_thresh_i),
    .mode_o          (cur_mode)
  );

  drc_sample_combiner #(
    .CNT_W(CNT_W), .ADC_W(ADC_W), .WGT_W(WGT_W), .SCL_W(SCL_W), .OUT_W(OUT_W)
  ) u_comb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .end_i       (per_end),
    .total_i     (flip_total),
    .mode_i      (cur_mode),
    .adc_valid_i (adc_valid_i),
    .adc_data_i  (adc_data_i),
    .cfg_weight_i(cfg_weight_i),
    .cfg_scale_i (cfg_scale_i),
    .valid_o     (sample_valid_o),
    .value_o     (sample_value_o),
    .mode_o      (sample_mode_o)
  );

  assign adc_convert_o  = per_start;
  assign range_direct_o = (cur_mode == RANGE_DIRECT);

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
  parameter int unsigned PERIOD_CYC = 200
) (
  input logic clk_i,
  input logic rst_ni,
  input logic adc_valid_i,
  input logic adc_convert_o,
  input logic range_direct_o,
  input logic sample_valid_o
);

  localparam int unsigned GW = $clog2(PERIOD_CYC + 2);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (adc_convert_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!sample_valid_o && !range_direct_o)
        else $error("R1 outputs active in reset");
    end
  end

  assert_convert_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_convert_o && seen_q) |-> (gap_q == GW'(PERIOD_CYC - 1)))
    else $error("R2 conversion spacing");

  assert_result_after_reading_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> $past(adc_valid_i))
    else $error("R3 result without reading");

  assert_range_at_boundary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(range_direct_o) |-> adc_convert_o)
    else $error("R10 range change off boundary");

endmodule

bind dual_range_combiner drc_checker #(.PERIOD_CYC(PERIOD_CYC)) u_drc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .adc_valid_i   (adc_valid_i),
  .adc_convert_o (adc_convert_o),
  .range_direct_o(range_direct_o),
  .sample_valid_o(sample_valid_o)
);

// File: tb/test_dual_range_combiner.sv
module test_dual_range_combiner;

  localparam int P = 20;
  localparam longint OMAX = 64'd4294967295;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        pulse_p = 1'b0, pulse_n = 1'b0;
  logic        adc_valid = 1'b0;
  logic [15:0] adc_data = '0;
  logic [15:0] cfg_max = 16'd12;
  logic [15:0] cfg_thr = 16'd1000;
  logic [31:0] cfg_wgt = 32'd100;
  logic [23:0] cfg_scl = 24'd50;
  logic        adc_convert, range_direct, s_valid, s_mode;
  logic [31:0] s_value;

  always #5 clk = ~clk;

  dual_range_combiner #(.PERIOD_CYC(P)) i_dual_range_combiner (
    .clk_i(clk), .rst_ni(rst_n), .pulse_p_i(pulse_p), .pulse_n_i(pulse_n),
    .adc_valid_i(adc_valid), .adc_data_i(adc_data),
    .cfg_max_count_i(cfg_max), .cfg_low_thresh_i(cfg_thr),
    .cfg_weight_i(cfg_wgt), .cfg_scale_i(cfg_scl),
    .adc_convert_o(adc_convert), .range_direct_o(range_direct),
    .sample_valid_o(s_valid), .sample_value_o(s_value), .sample_mode_o(s_mode)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus settings
  int pat = 0, level = 2000, jit = 0;
  int cyc = 0, dly = 0, narr = 0;

  always @(negedge clk) begin
    cyc++;
    case (pat)
      1: begin pulse_p = (cyc % 8 == 0); pulse_n = (cyc % 8 == 4); end
      2: begin pulse_p = (cyc % 2 == 0); pulse_n = (cyc % 2 == 0); end
      3: begin pulse_p = (cyc % 2 == 0); pulse_n = 1'b0; end
      default: begin pulse_p = 1'b0; pulse_n = 1'b0; end
    endcase
    adc_valid = 1'b0;
    if (!rst_n) begin
      dly = 0;
    end else begin
      if (dly > 0) begin
        dly--;
        if (dly == 0) begin
          adc_valid = 1'b1;
          adc_data  = 16'(level + (narr % 4) * jit);
          narr++;
        end
      end
      if (adc_convert) dly = 3;
    end
  end

  // behavioural reference, advanced on every rising edge
  int     m_cnt, m_mode, m_pulses, m_snap, m_smode, m_prev, m_have, m_back, m_pp, m_pn;
  int     m_ov, m_omode;
  longint m_oval;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_pulses = 0; m_snap = 0; m_smode = 0;
      m_prev = 0; m_have = 0; m_back = 0; m_pp = 0; m_pn = 0;
      m_ov = 0; m_omode = 0; m_oval = 0;
    end else begin
      int total, nmode, nback;
      bit fin;
      longint v;
      total = m_pulses + ((pulse_p && !m_pp) ? 1 : 0) + ((pulse_n && !m_pn) ? 1 : 0);
      if (total > 65535) total = 65535;
      m_pp = pulse_p; m_pn = pulse_n;
      fin = (m_cnt == P - 1);
      m_ov = 0;
      if (adc_valid) begin
        if (m_have != 0) begin
          if (m_smode != 0) v = longint'(adc_data) * longint'(cfg_scl);
          else v = longint'(m_snap) * longint'(cfg_wgt) + longint'(adc_data) - longint'(m_prev);
          if (v < 0) v = 0;
          if (v > OMAX) v = OMAX;
          m_ov = 1; m_oval = v; m_omode = m_smode;
        end
        m_prev = adc_data; m_have = 1;
      end
      nmode = m_mode; nback = m_back;
      if (fin) begin
        nback = 0;
        if (m_mode == 0 && total >= cfg_max) nmode = 1;
        else if (m_mode == 1 && m_back != 0) nmode = 0;
        m_snap = total; m_smode = m_mode; m_pulses = 0; m_cnt = 0;
      end else begin
        if (adc_valid && m_mode == 1 && adc_data < cfg_thr) nback = 1;
        m_pulses = total; m_cnt++;
      end
      m_mode = nmode; m_back = nback;
    end
  end

  int n_fc = 0, n_dir = 0, n_sat = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(adc_convert == (m_cnt == 0), "R2 conversion request", adc_convert, m_cnt == 0);
      chk(range_direct == m_mode[0], "R6 R7 range select", range_direct, m_mode);
      chk(s_valid == m_ov[0], "R3 result strobe", s_valid, m_ov);
      if (s_valid && m_ov != 0) begin
        chk(s_mode == m_omode[0], "R10 reported mode", s_mode, m_omode);
        if (m_oval == 0 || m_oval == OMAX) begin
          n_sat++;
          chk(s_value == m_oval, "R9 saturated result", s_value, m_oval);
        end else if (m_omode != 0) begin
          n_dir++;
          chk(s_value == m_oval, "R8 direct result", s_value, m_oval);
        end else begin
          n_fc++;
          chk(s_value == m_oval, "R4 R5 converter result", s_value, m_oval);
        end
      end
    end
  end

  task automatic periods(input int n);
    repeat (n * P) @(negedge clk);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(s_valid == 1'b0, "R1 reset strobe", s_valid, 0);
    chk(range_direct == 1'b0, "R1 reset range", range_direct, 0);
    rst_n = 1'b1;
    // converter range, alternating flips, rising/falling readings
    pat = 1; level = 2000; jit = 40;
    periods(6);
    // zero weight and a large drop: result below zero
    cfg_wgt = 32'd0; pat = 0; jit = 500;
    periods(5);
    // flips on both lines together exceed the limit
    cfg_wgt = 32'd100; pat = 2; level = 5000; jit = 10;
    periods(6);
    chk(range_direct == 1'b1, "R6 direct after high count", range_direct, 1);
    // reading below threshold returns to converter range
    pat = 3; level = 300; jit = 0;
    periods(5);
    chk(range_direct == 1'b0, "R7 back to converter", range_direct, 0);
    // large weight saturates in converter range
    cfg_max = 16'hFFFF; cfg_wgt = 32'h1000_0000; pat = 2;
    periods(4);
    // forced direct range with large scale saturates
    cfg_max = 16'd0; cfg_thr = 16'd0; cfg_scl = 24'hFF_FFFF; level = 60000;
    periods(4);
    // back to converter range
    cfg_max = 16'd12; cfg_thr = 16'd1000; cfg_wgt = 32'd100; cfg_scl = 24'd50;
    level = 500; jit = 20; pat = 1;
    periods(4);
    chk(n_fc > 0, "R5 converter results seen", n_fc, 1);
    chk(n_dir > 0, "R8 direct results seen", n_dir, 1);
    chk(n_sat > 1, "R9 saturated results seen", n_sat, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule